// File: doc/BRIEF.md
# Serial aab pattern recognizer

This block watches a one-bit serial stream in which each clock cycle carries one symbol: a is sent as 0 and b as 1. It raises its `match` output in the cycle when the newest symbol completes the run a, a, b. "Newest" means the symbol on the input in that same cycle. The output is Mealy. It is formed combinationally from the stored state and the present input, so a match shows in the cycle its final b arrives and needs no extra clock.

Three states are held in a two-bit register with fixed codes. Code 00 is idle. Code 01 means one a has been seen. Code 10 means two or more a have been seen in a row. The next state comes from fixed minimised sum-of-products equations. Code 11 is never used, and those equations move it to 10 on an a and to 00 on a b, so it cannot trap the machine. A synchronous reset returns the register to 00. Overlapping matches need no special handling: a long run of a followed by b matches once, and a fresh a, a, b right after a match matches again.

Top module: `aab_recognizer`

## Requirements
- R1: On a clock edge with `rst` high, the state returns to idle. In the following cycle a b on `symIn` gives `match` = 0.
- R2: `match` is 1 exactly when `symIn` is 1 in the present cycle and was 0 in each of the two cycles before, with no reset edge in between. Otherwise it is 0.
- R3: The symbol a is `symIn` = 0 and the symbol b is `symIn` = 1.
- R4: A run of three or more a followed by b raises `match` once, on the b.
- R5: A b always returns the machine to idle. After a match, or after the pair a, b, a further b gives `match` = 0.
- R6: Reset takes effect at the edge regardless of `symIn`. Symbols seen before a reset edge never count toward a later match.
- R7: The state register never holds the unused code 11.
- R8: `match` follows `symIn` within a cycle, with no clock edge needed. In the state reached after two a, setting `symIn` to 1 raises `match` and setting it back to 0 lowers it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state advances on the rising edge |
| rst | input | 1 | Synchronous reset, active high, forces idle |
| symIn | input | 1 | Serial symbol: 0 = a, 1 = b |
| match | output | 1 | Mealy output: high when the last three symbols are a, a, b |

## Verification
The block has no size or behaviour parameters, so the bench builds the one fixed form. From the ports it reaches every used state and every arc between them. That includes the self-loop on long runs of a, back-to-back matches, and reset both during a partial match and during an idle stretch. The unused code cannot be entered through the ports. The checker therefore watches that it never appears, and it also checks that every b leads back to idle.

// File: rtl/aab_pkg.sv
package aab_pkg;

  localparam int STATE_BITS = 2;

  typedef enum logic [STATE_BITS-1:0] {
    ST_IDLE = 2'b00,
    ST_ONE_A = 2'b01,
    ST_TWO_A = 2'b10,
    ST_SPARE = 2'b11
  } detState_e;

  // strobes from control to the state datapath
  typedef struct packed {
    logic nextHi;
    logic nextLo;
    logic hit;
  } detStrobes_t;

endpackage

// File: rtl/aab_ctrl.sv
module aab_ctrl
  import aab_pkg::*;
(
  input  logic                  symIn,
  input  logic [STATE_BITS-1:0] stateQ,
  output detStrobes_t           strobes
);

  logic isA;
  logic q1;
  logic q0;

  always_comb begin
    isA = ~symIn;
    q1  = stateQ[1];
    q0  = stateQ[0];
    // minimised next-state and output equations
    strobes.nextHi = (isA & q0) | (isA & q1);
    strobes.nextLo = ~q1 & ~q0 & isA;
    strobes.hit    = q1 & symIn;
  end

endmodule

// File: rtl/aab_state_dp.sv
module aab_state_dp
  import aab_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  detStrobes_t           strobes,
  output logic [STATE_BITS-1:0] stateQ,
  output logic                  match
);

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= {strobes.nextHi, strobes.nextLo};
  end

  assign match = strobes.hit;

endmodule

// File: rtl/aab_recognizer.sv
module aab_recognizer
  import aab_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic symIn,
  output logic match
);

  detStrobes_t           strobes;
  logic [STATE_BITS-1:0] stateQ;

  aab_ctrl uCtrl (
    .symIn  (symIn),
    .stateQ (stateQ),
    .strobes(strobes)
  );

  aab_state_dp uDp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .stateQ (stateQ),
    .match  (match)
  );

endmodule

// File: rtl/aab_recognizer_chk.sv
module aab_recognizer_chk (
  input logic       clk,
  input logic       rst,
  input logic       symIn,
  input logic       match,
  input logic [1:0] stateQ
);

  AST_RESET_TO_IDLE: assert property (@(posedge clk) $past(rst) |-> stateQ == 2'b00); // R1

  AST_MATCH_AFTER_AA: assert property (@(posedge clk) disable iff (rst)
    match |-> (symIn && !$past(symIn) && !$past(symIn, 2))); // R2

  AST_B_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    symIn |=> stateQ == 2'b00); // R5

  AST_NO_SPARE_CODE: assert property (@(posedge clk) disable iff (rst)
    stateQ != 2'b11); // R7

endmodule

bind aab_recognizer aab_recognizer_chk uChk (
  .clk   (clk),
  .rst   (rst),
  .symIn (symIn),
  .match (match),
  .stateQ(stateQ)
);

// File: tb/aab_recognizer_test.sv
`timescale 1ns/1ps
module aab_recognizer_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic symIn = 1'b0;
  logic match;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  aab_recognizer uut (
    .clk  (clk),
    .rst  (rst),
    .symIn(symIn),
    .match(match)
  );

  // {rst, symIn, expected match, requirement number}
  localparam int NVEC = 21;
  localparam logic [7:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b0, 5'd1},  // R1 held in reset
    {1'b0, 1'b1, 1'b0, 5'd1},  // R1 b from idle
    {1'b0, 1'b0, 1'b0, 5'd3},  // R3 a
    {1'b0, 1'b0, 1'b0, 5'd3},  // R3 a
    {1'b0, 1'b1, 1'b1, 5'd2},  // R2 aab
    {1'b0, 1'b1, 1'b0, 5'd5},  // R5 b after match
    {1'b0, 1'b0, 1'b0, 5'd5},  // R5 a
    {1'b0, 1'b1, 1'b0, 5'd5},  // R5 ab no match
    {1'b0, 1'b0, 1'b0, 5'd4},  // R4 a
    {1'b0, 1'b0, 1'b0, 5'd4},  // R4 a
    {1'b0, 1'b0, 1'b0, 5'd4},  // R4 a
    {1'b0, 1'b0, 1'b0, 5'd4},  // R4 a
    {1'b0, 1'b1, 1'b1, 5'd4},  // R4 aaaab
    {1'b0, 1'b0, 1'b0, 5'd2},  // R2 a
    {1'b0, 1'b0, 1'b0, 5'd2},  // R2 a
    {1'b1, 1'b0, 1'b0, 5'd6},  // R6 reset after aa
    {1'b0, 1'b1, 1'b0, 5'd6},  // R6 b must not match
    {1'b0, 1'b0, 1'b0, 5'd6},  // R6 a
    {1'b1, 1'b0, 1'b0, 5'd6},  // R6 reset after one a
    {1'b0, 1'b0, 1'b0, 5'd6},  // R6 a
    {1'b0, 1'b1, 1'b0, 5'd6}   // R6 ab no match
  };

  task automatic check(input logic exp, input string req);
    checks++;
    if (match !== exp) begin
      fails++;
      $display("FAIL %s: match actual=%b expected=%b at %0t", req, match, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic x);
    @(negedge clk);
    rst = r;
    symIn = x;
  endtask

  initial begin
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][7], VEC[i][6]);
      #1;
      check(VEC[i][5], $sformatf("R%0d", VEC[i][4:0]));
    end

    // R8: combinational response within one low phase
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    #1 check(1'b0, "R8");
    symIn = 1'b1;
    #1 check(1'b1, "R8");
    symIn = 1'b0;
    #1 check(1'b0, "R8");

    // R4: long run of a, then back-to-back matches
    for (int i = 0; i < 12; i++) begin
      step(1'b0, 1'b0);
      #1 check(1'b0, "R4");
    end
    step(1'b0, 1'b1);
    #1 check(1'b1, "R4");
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    #1 check(1'b1, "R2");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule